// File: doc/BRIEF.md
# External Trigger Conditioner for an ADC Sequencer

This block turns an asynchronous trigger pin into clean start and gate signals for the controller that runs conversion sequences. The pin is first resynchronised into the clock domain. The polarity-corrected result then drives one of two behaviours. In edge mode, each active edge produces a single-cycle start request. In level mode, a gate output stays high for as long as the pin holds its active level.

A sequence-busy input from the converter controller tells the block whether a sequence is already running. An active edge that arrives while the controller is busy does not start anything. Instead it raises a sticky overrun flag, which a status write clears. In level mode, a conversion-done input lets the gate fall only on a conversion boundary. The conversion that is running when the pin goes inactive is therefore allowed to finish.

Top module: `adc_xtrig_unit`

## Requirements
- R1: After synchronous reset, start_req, gate_run and overrun_flag are all 0.
- R2: With cfg_enable = 0, pin activity produces no start_req, no gate_run and no overrun_flag, whatever the mode and polarity.
- R3: In edge mode (cfg_level_mode = 0), cfg_active_high = 1 makes a rising pin edge active and cfg_active_high = 0 makes a falling pin edge active. The opposite edge has no effect.
- R4: An accepted active edge gives a start_req pulse exactly one cycle wide. The pulse appears SYNC_STAGES + 1 clock edges after the pin change.
- R5: An active edge that arrives while seq_busy = 1 produces no start_req and sets overrun_flag. The flag is set with the same latency as a start pulse.
- R6: overrun_flag holds until ovr_clear is high at a clock edge, and it reads 0 in the following cycle. A new overrun in the same cycle as the clear wins, and the flag stays 1.
- R7: In level mode (cfg_level_mode = 1, enabled), gate_run follows the pin at the active level set by cfg_active_high, with a latency of SYNC_STAGES + 1 edges. Level mode never produces start_req or sets overrun_flag.
- R8: In level mode, when the pin goes inactive while seq_busy = 1 and conv_done = 0, gate_run stays high. It falls on the edge after conv_done is seen high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_pin | input | 1 | Asynchronous external trigger |
| cfg_enable | input | 1 | 1 lets the trigger act, 0 ignores it |
| cfg_level_mode | input | 1 | 1 selects level gating, 0 selects edge start |
| cfg_active_high | input | 1 | 1 selects high level or rising edge, 0 selects low level or falling edge |
| seq_busy | input | 1 | A conversion sequence is running |
| conv_done | input | 1 | The current conversion ends this cycle |
| ovr_clear | input | 1 | Status write that clears the overrun flag |
| start_req | output | 1 | One-cycle sequence start request |
| gate_run | output | 1 | Level-mode conversion gate |
| overrun_flag | output | 1 | Sticky trigger-overrun flag |

## Verification
The bench builds the block with the default SYNC_STAGES = 2, so every output reacts three edges after a pin change. The bench sweeps all combinations of enable, mode, polarity, busy and edge direction. For each one it computes the expected start, gate and overrun values from those five bits. It then checks the pulse width and flag retention one cycle later. Directed cases cover two timing corners: an overrun that lands in the same cycle as a clear, and a level-mode gate held across a busy conversion until conv_done.

// File: rtl/adc_xtrig_pkg.sv
package adc_xtrig_pkg;

    typedef struct packed {
        logic enable;
        logic level_mode;
        logic active_high;
    } xtrig_cfg_t;

    typedef struct packed {
        logic act_edge;
        logic act_level;
    } xtrig_evt_t;

    function automatic logic pick_edge(input logic rise, input logic fall,
                                       input logic active_high);
        return active_high ? rise : fall;
    endfunction

    function automatic logic pick_level(input logic lvl, input logic active_high);
        return active_high ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/xtrig_sync.sv
module xtrig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[i] <= 1'b0;
                else if (i == 0)
                    chain[i] <= d;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i - 1];
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/xtrig_detect.sv
module xtrig_detect
    import adc_xtrig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_sync,
    input  logic       active_high,
    output xtrig_evt_t evt
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst)
            prev <= 1'b0;
        else
            prev <= pin_sync;
    end

    always_comb begin
        evt.act_edge  = pick_edge(pin_sync & ~prev, ~pin_sync & prev, active_high);
        evt.act_level = pick_level(pin_sync, active_high);
    end
endmodule

// File: rtl/xtrig_ctrl.sv
module xtrig_ctrl
    import adc_xtrig_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  xtrig_cfg_t cfg,
    input  xtrig_evt_t evt,
    input  logic       seq_busy,
    input  logic       conv_done,
    input  logic       ovr_clear,
    output logic       start_req,
    output logic       gate_run,
    output logic       overrun_flag
);
    logic edge_ok;
    logic gate_nxt;

    always_comb begin
        edge_ok  = cfg.enable & ~cfg.level_mode & evt.act_edge;
        gate_nxt = cfg.enable & cfg.level_mode &
                   (evt.act_level | (gate_run & seq_busy & ~conv_done));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_req    <= 1'b0;
            gate_run     <= 1'b0;
            overrun_flag <= 1'b0;
        end else begin
            start_req <= edge_ok & ~seq_busy;
            gate_run  <= gate_nxt;
            if (edge_ok & seq_busy)
                overrun_flag <= 1'b1;
            else if (ovr_clear)
                overrun_flag <= 1'b0;
        end
    end

    a_r4_start_from_edge_mode: assert property (@(posedge clk) disable iff (rst)
        start_req |-> ($past(cfg.enable) && !$past(cfg.level_mode)));
    a_r5_start_never_when_busy: assert property (@(posedge clk) disable iff (rst)
        start_req |-> !$past(seq_busy));
    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        (overrun_flag && !ovr_clear) |=> overrun_flag);
    a_r2_gate_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !cfg.enable |=> !gate_run);
    a_r7_start_gate_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(start_req && gate_run));
    a_r8_gate_held_in_conversion: assert property (@(posedge clk) disable iff (rst)
        (gate_run && seq_busy && !conv_done && cfg.enable && cfg.level_mode) |=> gate_run);
endmodule

// File: rtl/adc_xtrig_unit.sv
module adc_xtrig_unit
    import adc_xtrig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_pin,
    input  logic cfg_enable,
    input  logic cfg_level_mode,
    input  logic cfg_active_high,
    input  logic seq_busy,
    input  logic conv_done,
    input  logic ovr_clear,
    output logic start_req,
    output logic gate_run,
    output logic overrun_flag
);
    xtrig_cfg_t cfg;
    xtrig_evt_t evt;
    logic       pin_sync;

    assign cfg = '{enable: cfg_enable, level_mode: cfg_level_mode,
                   active_high: cfg_active_high};

    xtrig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (trig_pin),
        .q   (pin_sync)
    );

    xtrig_detect u_detect (
        .clk         (clk),
        .rst         (rst),
        .pin_sync    (pin_sync),
        .active_high (cfg_active_high),
        .evt         (evt)
    );

    xtrig_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cfg          (cfg),
        .evt          (evt),
        .seq_busy     (seq_busy),
        .conv_done    (conv_done),
        .ovr_clear    (ovr_clear),
        .start_req    (start_req),
        .gate_run     (gate_run),
        .overrun_flag (overrun_flag)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!start_req && !gate_run && !overrun_flag));
    a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        start_req |-> $past(cfg_enable));
endmodule

// File: tb/test_adc_xtrig_unit.sv
module test_adc_xtrig_unit;
    localparam int SYNC_STAGES = 2;
    localparam int LAT = SYNC_STAGES + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_pin = 1'b0;
    logic cfg_enable = 1'b0, cfg_level_mode = 1'b0, cfg_active_high = 1'b1;
    logic seq_busy = 1'b0, conv_done = 1'b1, ovr_clear = 1'b0;
    logic start_req, gate_run, overrun_flag;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    adc_xtrig_unit #(.SYNC_STAGES(SYNC_STAGES)) i_adc_xtrig_unit (
        .clk(clk), .rst(rst), .trig_pin(trig_pin),
        .cfg_enable(cfg_enable), .cfg_level_mode(cfg_level_mode),
        .cfg_active_high(cfg_active_high), .seq_busy(seq_busy),
        .conv_done(conv_done), .ovr_clear(ovr_clear),
        .start_req(start_req), .gate_run(gate_run), .overrun_flag(overrun_flag)
    );

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic clear_ovr();
        @(negedge clk) ovr_clear = 1'b1;
        @(negedge clk) ovr_clear = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "start_req", start_req, 1'b0);
        chk("R1", "gate_run", gate_run, 1'b0);
        chk("R1", "overrun_flag", overrun_flag, 1'b0);
        @(negedge clk) rst = 1'b0;

        // Sweep R2 R3 R4 R5 R7: enable, mode, polarity, busy, edge direction
        for (int k = 0; k < 32; k++) begin
            logic en, lvl, pol, busy, dir;
            logic edge_ok, exp_start, exp_ovr, exp_gate;
            string tag;
            en = k[4]; lvl = k[3]; pol = k[2]; busy = k[1]; dir = k[0];
            @(negedge clk);
            cfg_enable = en; cfg_level_mode = lvl; cfg_active_high = pol;
            seq_busy = busy; conv_done = 1'b1; trig_pin = ~dir;
            repeat (6) @(negedge clk);
            clear_ovr();
            chk("R6", "ovr after clear", overrun_flag, 1'b0);
            chk("R7", "gate before toggle", gate_run, en & lvl & ((~dir) == pol));
            trig_pin = dir;
            edge_ok   = en & ~lvl & (dir == pol);
            exp_start = edge_ok & ~busy;
            exp_ovr   = edge_ok & busy;
            exp_gate  = en & lvl & (dir == pol);
            tag = !en ? "R2" : (lvl ? "R7" : (busy ? "R5" : "R3"));
            repeat (LAT - 1) @(posedge clk);
            #1;
            chk("R4", "start early", start_req, 1'b0);
            @(posedge clk);
            #1;
            chk(tag, "start_req", start_req, exp_start);
            chk(tag, "overrun_flag", overrun_flag, exp_ovr);
            chk(tag, "gate_run", gate_run, exp_gate);
            @(posedge clk);
            #1;
            chk("R4", "pulse width", start_req, 1'b0);
            chk("R6", "flag held", overrun_flag, exp_ovr);
        end

        // R6: overrun set in the same cycle as a clear keeps the flag
        @(negedge clk);
        cfg_enable = 1'b1; cfg_level_mode = 1'b0; cfg_active_high = 1'b1;
        seq_busy = 1'b1; trig_pin = 1'b0;
        repeat (6) @(negedge clk);
        clear_ovr();
        trig_pin = 1'b1;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk) ovr_clear = 1'b1;
        @(posedge clk);
        #1;
        ovr_clear = 1'b0;
        chk("R6", "set beats clear", overrun_flag, 1'b1);
        repeat (4) @(posedge clk);
        #1;
        chk("R6", "flag still held", overrun_flag, 1'b1);
        @(negedge clk) ovr_clear = 1'b1;
        @(posedge clk);
        #1;
        ovr_clear = 1'b0;
        chk("R6", "cleared", overrun_flag, 1'b0);

        // R8: gate held through a busy conversion until conv_done
        @(negedge clk);
        cfg_level_mode = 1'b1; cfg_active_high = 1'b1;
        seq_busy = 1'b1; conv_done = 1'b0; trig_pin = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8", "gate on", gate_run, 1'b1);
        trig_pin = 1'b0;
        repeat (LAT + 3) @(posedge clk);
        #1;
        chk("R8", "gate held", gate_run, 1'b1);
        @(negedge clk) conv_done = 1'b1;
        @(posedge clk);
        #1;
        chk("R8", "gate released", gate_run, 1'b0);
        chk("R7", "no start in level mode", start_req, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule